// File: doc/BRIEF.md
# Write-After-Write Issue Interlock

This block sits at the issue point of a small in-order pipeline that feeds two execution units of different fixed latency: a multi-cycle multiplier and a single-cycle adder/subtractor. Each cycle it looks at one decoded instruction: its unit, whether it writes a result, its destination register and two source registers. It then decides whether the instruction may leave decode or must be held for another cycle while a bubble goes down the pipe.

The block keeps, for every architectural register, a countdown of the cycles left until the youngest pending write to that register completes. It also keeps a short schedule of writebacks on the single result port. From these two it computes three stall causes. A source is still pending (read-after-write). A new write would land no later than the pending write to the same destination, which would leave the older value in the register (write-after-write). The result port is already booked in the cycle the new write would land. Register 0 always reads zero and takes part in none of this. Counters keep running while issue is held.

The writeback port is visible at the block's outputs as the register written in each cycle. This lets the surrounding datapath steer results, and lets a bench see the order in which writes land.

Top module: `waw_issue_interlock`

## Requirements
- R1: A synchronous reset, including one taken while writes are in flight, clears all pending state. In the cycle after reset there is no writeback and no stall, and no write issued before the reset ever lands.
- R2: A write to a nonzero register on the adder (`in_unit` = 0) that issues in cycle t appears on the writeback port (`wb_valid` = 1, `wb_reg` = destination) in cycle t + ADD_LAT.
- R3: A write to a nonzero register on the multiplier (`in_unit` = 1) that issues in cycle t appears on the writeback port in cycle t + MUL_LAT.
- R4: An instruction with a nonzero source register that has a pending write is held until the cycle after that write appears on the writeback port. This holds for either source.
- R5: Take a write of latency L to a register whose youngest pending write lands k cycles from now (k = 0 is the current cycle). It is held while L <= k and issues as soon as L > k. The last write to reach a register is therefore always the youngest in program order.
- R6: A write of latency L is held when another write, to any register, is already scheduled on the writeback port exactly L cycles from now.
- R7: Register 0 never stalls as a source. A write to register 0 issues without any destination or port check, and it never appears on the writeback port.
- R8: `stall` is low whenever `in_valid` is low. `issue` equals `in_valid` and not `stall`.
- R9: An instruction with `in_wr` = 0 is checked only against its sources and produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 1 | Execution unit: 0 adder, 1 multiplier |
| in_wr | input | 1 | Instruction writes its destination |
| in_dst | input | $clog2(NREGS) | Destination register |
| in_src_a | input | $clog2(NREGS) | First source register |
| in_src_b | input | $clog2(NREGS) | Second source register |
| stall | output | 1 | Hold the instruction in decode and insert a bubble |
| issue | output | 1 | Instruction leaves decode this cycle |
| wb_valid | output | 1 | A result is written this cycle |
| wb_reg | output | $clog2(NREGS) | Register written this cycle |

## Verification
The hardest case to reach is a port collision between writes to different registers. It only occurs when an adder write arrives exactly MUL_LAT - ADD_LAT - 1 cycles after a multiply, and a fixed program rarely lines that up. The bench therefore sweeps the gap between a multiply and a following add over every value from back-to-back to past the multiply latency. It does this for a shared destination, for a dependent source on each side and for unrelated registers. For every gap it computes the expected issue cycle and writeback cycles from the latencies. A reset taken with a multiply in flight is also driven, to show that the discarded write never lands.

// File: rtl/waw_pkg.sv
package waw_pkg;

    typedef enum logic {
        UNIT_ADD = 1'b0,
        UNIT_MUL = 1'b1
    } unit_e;

endpackage

// File: rtl/pend_table.sv
module pend_table #(
    parameter int NREGS = 32,
    parameter int CNT_W = 3,
    parameter int NQ    = 4,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [CNT_W-1:0] set_val,
    input  logic [REG_W-1:0] qry_reg [NQ],
    output logic [CNT_W-1:0] qry_cnt [NQ]
);

    typedef struct packed {
        logic [NREGS-1:0][CNT_W-1:0] cnt;
    } pend_s;

    pend_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREGS; i++) begin
            if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
        end
        if (set_en) begin
            st_d.cnt[set_reg] = set_val;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_qry
        assign qry_cnt[g] = st_q.cnt[qry_reg[g]];
    end

    // R7
    zero_reg_untracked_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |-> (set_reg != '0 && set_val != '0));

endmodule

// File: rtl/wb_schedule.sv
module wb_schedule #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [CNT_W-1:0] push_lat,
    input  logic [REG_W-1:0] push_reg,
    input  logic [CNT_W-1:0] chk_lat,
    output logic             chk_busy,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg
);

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] r;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] s;
    } sched_s;

    sched_s sch_d, sch_q;

    always_comb begin
        sch_d = '0;
        for (int k = 0; k < DEPTH - 1; k++) begin
            sch_d.s[k] = sch_q.s[k+1];
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (push_en && push_lat == CNT_W'(k + 1)) begin
                sch_d.s[k].vld = 1'b1;
                sch_d.s[k].r   = push_reg;
            end
        end
        if (rst) begin
            sch_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sch_q <= sch_d;
    end

    always_comb begin
        chk_busy = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (chk_lat == CNT_W'(k)) begin
                chk_busy = sch_q.s[k].vld;
            end
        end
    end

    assign wb_valid = sch_q.s[0].vld;
    assign wb_reg   = sch_q.s[0].r;

    logic push_clash;
    always_comb begin
        push_clash = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            if (push_en && push_lat == CNT_W'(k) && sch_q.s[k].vld) begin
                push_clash = 1'b1;
            end
        end
    end

    // R6
    wb_port_free_chk: assert property (@(posedge clk) disable iff (rst)
        !push_clash);

endmodule

// File: rtl/waw_issue_interlock.sv
module waw_issue_interlock
    import waw_pkg::*;
#(
    parameter int NREGS   = 32,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 1,
    localparam int REG_W  = $clog2(NREGS),
    localparam int CNT_W  = $clog2(MUL_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_unit,
    input  logic             in_wr,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    output logic             stall,
    output logic             issue,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg
);

    localparam int NQ = 4;

    unit_e            unit_sel;
    logic [CNT_W-1:0] lat_sel;
    logic             wr_real;
    logic             hz_src_a, hz_src_b, hz_waw, hz_port;
    logic             port_busy;
    logic             commit_wr;

    logic [REG_W-1:0] q_reg [NQ];
    logic [CNT_W-1:0] q_cnt [NQ];

    assign q_reg[0] = in_src_a;
    assign q_reg[1] = in_src_b;
    assign q_reg[2] = in_dst;
    assign q_reg[3] = wb_reg;

    assign unit_sel = unit_e'(in_unit);
    assign lat_sel  = (unit_sel == UNIT_MUL) ? CNT_W'(MUL_LAT) : CNT_W'(ADD_LAT);
    assign wr_real  = in_wr && (in_dst != '0);

    // A source waits until its count has run out (the write has landed).
    assign hz_src_a = (in_src_a != '0) && (q_cnt[0] != '0);
    assign hz_src_b = (in_src_b != '0) && (q_cnt[1] != '0);
    // Pending count c means landing c-1 cycles from now; new write must land later.
    assign hz_waw   = wr_real && (lat_sel < q_cnt[2]);
    assign hz_port  = wr_real && port_busy;

    assign stall     = in_valid && (hz_src_a || hz_src_b || hz_waw || hz_port);
    assign issue     = in_valid && !stall;
    assign commit_wr = issue && wr_real;

    pend_table #(
        .NREGS (NREGS),
        .CNT_W (CNT_W),
        .NQ    (NQ)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (commit_wr),
        .set_reg (in_dst),
        .set_val (lat_sel),
        .qry_reg (q_reg),
        .qry_cnt (q_cnt)
    );

    wb_schedule #(
        .DEPTH (MUL_LAT),
        .REG_W (REG_W),
        .CNT_W (CNT_W)
    ) u_sched (
        .clk      (clk),
        .rst      (rst),
        .push_en  (commit_wr),
        .push_lat (lat_sel),
        .push_reg (in_dst),
        .chk_lat  (lat_sel),
        .chk_busy (port_busy),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    // R8
    stall_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !stall);

    // R5
    wb_youngest_pending_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (q_cnt[3] != '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wb_valid && !stall));

    // R7
    wb_not_zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_reg != '0));

endmodule

// File: tb/waw_issue_interlock_tb.sv
module waw_issue_interlock_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 32;
    localparam int MUL_LAT    = 4;
    localparam int ADD_LAT    = 1;
    localparam int REG_W      = $clog2(NREGS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_unit = 1'b0;
    logic             in_wr = 1'b0;
    logic [REG_W-1:0] in_dst = '0;
    logic [REG_W-1:0] in_src_a = '0;
    logic [REG_W-1:0] in_src_b = '0;
    logic             stall, issue, wb_valid;
    logic [REG_W-1:0] wb_reg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int wb_cyc [64];
    int wb_r   [64];
    int nwb = 0;

    waw_issue_interlock #(
        .NREGS   (NREGS),
        .MUL_LAT (MUL_LAT),
        .ADD_LAT (ADD_LAT)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_unit  (in_unit),
        .in_wr    (in_wr),
        .in_dst   (in_dst),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .stall    (stall),
        .issue    (issue),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        #2;
        if (wb_valid && nwb < 64) begin
            wb_cyc[nwb] = cyc;
            wb_r[nwb]   = int'(wb_reg);
            nwb++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nth_wb(input int r, input int n);
        int seen = 0;
        for (int i = 0; i < nwb; i++) begin
            if (wb_r[i] == r) begin
                if (seen == n) return wb_cyc[i];
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic int count_wb(input int r);
        int c = 0;
        for (int i = 0; i < nwb; i++) if (wb_r[i] == r) c++;
        return c;
    endfunction

    // Called just after a falling edge; returns the cycle in which issue was high.
    task automatic send(input logic unit, input logic wr, input int dst,
                        input int a, input int b, output int icyc);
        in_valid = 1'b1;
        in_unit  = unit;
        in_wr    = wr;
        in_dst   = REG_W'(dst);
        in_src_a = REG_W'(a);
        in_src_b = REG_W'(b);
        icyc = -1;
        for (int n = 0; n < 40; n++) begin
            #1;
            if (issue) begin
                icyc = cyc;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, st, exp_t;

        // R1: reset state, with an instruction already presented
        in_valid = 1'b1; in_wr = 1'b1; in_dst = 5'd5; in_src_a = 5'd5; in_src_b = 5'd9;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall after reset", int'(stall), 0);
        chk("R1 wb_valid after reset", int'(wb_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        idle(2);

        // R5: multiply then add to the same register, every gap
        for (int g = 0; g <= 5; g++) begin
            nwb = 0;
            send(1'b1, 1'b1, 5, 1, 2, t0);
            idle(g);
            send(1'b0, 1'b1, 5, 7, 8, t1);
            idle(8);
            exp_t = (t0 + 1 + g > t0 + MUL_LAT - ADD_LAT + 1) ? t0 + 1 + g
                                                              : t0 + MUL_LAT - ADD_LAT + 1;
            chk($sformatf("R5 waw issue gap %0d", g), t1, exp_t);
            chk($sformatf("R3 mul wb gap %0d", g), nth_wb(5, 0), t0 + MUL_LAT);
            chk($sformatf("R2 add wb last gap %0d", g), nth_wb(5, 1), t1 + ADD_LAT);
            chk($sformatf("R5 wb count gap %0d", g), count_wb(5), 2);
        end

        // R4: dependent read on either source, every gap
        for (int side = 0; side < 2; side++) begin
            for (int g = 0; g <= 5; g++) begin
                nwb = 0;
                send(1'b1, 1'b1, 5, 1, 2, t0);
                idle(g);
                send(1'b0, 1'b1, 9, (side == 0) ? 5 : 3, (side == 1) ? 5 : 3, t1);
                idle(8);
                exp_t = (t0 + 1 + g > t0 + MUL_LAT + 1) ? t0 + 1 + g : t0 + MUL_LAT + 1;
                chk($sformatf("R4 raw issue side %0d gap %0d", side, g), t1, exp_t);
                chk($sformatf("R2 reader wb side %0d gap %0d", side, g), nth_wb(9, 0), t1 + ADD_LAT);
            end
        end

        // R6: port collision between unrelated registers
        for (int g = 0; g <= 4; g++) begin
            nwb = 0;
            send(1'b1, 1'b1, 3, 0, 0, t0);
            idle(g);
            send(1'b0, 1'b1, 7, 0, 0, t1);
            idle(8);
            exp_t = t0 + 1 + g;
            if (exp_t + ADD_LAT == t0 + MUL_LAT) exp_t = exp_t + 1;
            chk($sformatf("R6 port issue gap %0d", g), t1, exp_t);
            chk($sformatf("R6 wb r7 gap %0d", g), nth_wb(7, 0), t1 + ADD_LAT);
            chk($sformatf("R3 wb r3 gap %0d", g), nth_wb(3, 0), t0 + MUL_LAT);
        end

        // R5: two multiplies to one register issue back to back, land in order
        nwb = 0;
        send(1'b1, 1'b1, 6, 1, 2, t0);
        send(1'b1, 1'b1, 6, 1, 2, t1);
        idle(8);
        chk("R5 mul-mul no stall", t1, t0 + 1);
        chk("R5 mul-mul first wb", nth_wb(6, 0), t0 + MUL_LAT);
        chk("R5 mul-mul last wb", nth_wb(6, 1), t1 + MUL_LAT);

        // R8: no stall while nothing is presented, even with writes pending
        send(1'b1, 1'b1, 5, 1, 2, t0);
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 stall with in_valid low", int'(stall), 0);
            @(negedge clk);
        end
        idle(6);

        // R7: register 0 as destination and source
        nwb = 0;
        send(1'b1, 1'b1, 0, 1, 2, t0);
        send(1'b0, 1'b1, 0, 0, 0, t1);
        send(1'b0, 1'b1, 4, 0, 0, t2);
        idle(8);
        chk("R7 r0 write no waw stall", t1, t0 + 1);
        chk("R7 r0 source no stall", t2, t1 + 1);
        chk("R7 r0 never written", count_wb(0), 0);

        // R9: non-writing instruction ignores destination hazards
        nwb = 0;
        send(1'b1, 1'b1, 5, 1, 2, t0);
        send(1'b0, 1'b0, 5, 0, 0, t1);
        idle(8);
        chk("R9 no-write issue", t1, t0 + 1);
        chk("R9 no-write adds no wb", count_wb(5), 1);

        // R1: reset with a multiply in flight
        nwb = 0;
        send(1'b1, 1'b1, 5, 1, 2, t0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        st = cyc;
        send(1'b0, 1'b1, 9, 5, 0, t1);
        idle(8);
        chk("R1 reader after reset no stall", t1, st);
        chk("R1 flushed write never lands", count_wb(5), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule